// File: doc/BRIEF.md
# Interrupt Context Save and Restore Sequencer

This block moves a processor's working context to and from a small stack page in memory, one byte per cycle. When the interrupt logic accepts a request, the sequencer captures the program counter, index register, accumulator and condition code register. It writes them as a five-byte frame through a byte-wide memory port, sets the interrupt mask bit in its copy of the condition codes, and then reads a two-byte handler address from a vector location chosen outside the block.

When a return-from-interrupt is decoded elsewhere, the sequencer reads the same five bytes back in the opposite order and presents the restored registers. The restored condition codes carry the mask bit as it was before the interrupt.

The stack pointer is internal. It is reset to the top of the page, and it never leaves the page: its high address bits are a fixed page base, and only the low bits count. Priority selection, instruction decoding and the memory itself sit outside this block. The memory port returns read data in the same cycle as the address.

Top module: `ctx_stacker`

## Requirements
- R1: After reset the block is idle with `busy`, `done`, `mem_we` and `mem_re` low, and the pointer holds all ones, so the first write of the first frame goes to page base plus 2^SP_BITS-1.
- R2: An accepted entry writes five bytes on consecutive cycles, one write per cycle, in the order PC bits 7:0, PC bits 15:8, X, A, CCR.
- R3: Each push writes at the current pointer and then decrements it. Each pop increments the pointer and then reads there. The pointer counts only SP_BITS bits, so it wraps inside the page in both directions.
- R4: Straight after the fifth push, two read cycles fetch the vector. The first read is at `vec_base` with bit 0 forced to 0 and gives PC bits 15:8. The second read is at `vec_base` with bit 0 forced to 1 and gives PC bits 7:0. The new PC then appears on `pc_out`.
- R5: After an entry, `ccr_out` equals the captured CCR with bit IBIT (bit 3) set. `x_out` and `a_out` equal the captured X and A.
- R6: A return performs five reads at rising addresses, taking CCR, A, X, PC bits 15:8 and PC bits 7:0 in that order. All four output registers are reloaded from them, and the mask bit comes back exactly as it was stored.
- R7: `busy` is high from the cycle after the request until the new PC is loaded. That is 7 cycles for an entry and 5 for a return. It is followed by a single-cycle `done` pulse with `busy` low and the outputs valid.
- R8: `irq_take` and `rti_take` are ignored while `busy` is high. If both are high in the same idle cycle, the entry wins and the return request is dropped.
- R9: `mem_we` and `mem_re` are never high together. Every stack access lies inside the page given by STACK_BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_take | input | 1 | Start a context save and vector fetch |
| rti_take | input | 1 | Start a context restore |
| vec_base | input | AW | Address of the selected vector pair |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | Index register to save |
| a_in | input | 8 | Accumulator to save |
| ccr_in | input | 8 | Condition codes to save |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| pc_out | output | 16 | Handler address or restored PC |
| x_out | output | 8 | Saved or restored X |
| a_out | output | 8 | Saved or restored A |
| ccr_out | output | 8 | CCR with mask set, or restored CCR |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the outputs are valid |

## Verification
The bench builds the block with SP_BITS=4 and STACK_BASE=16'h00F0. This gives a 16-byte page, so the pointer wraps inside the page after three nested frames.

Twenty nested entries followed by twenty returns therefore cross the wrap point in both directions, including frames that were partly overwritten. Each step is checked against addresses and bytes that the bench computes from its own pointer count.

Vector bases sweep all five even slots, and the saved condition codes alternate the mask bit clear and set. Stray return and entry requests are injected both during a sequence and in the same idle cycle as an entry.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int PC_W        = 16;
    localparam int FRAME_BYTES = 5;
    localparam int CNT_W       = 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PUSH = 3'd1,
        ST_VHI  = 3'd2,
        ST_VLO  = 3'd3,
        ST_POP  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/ctx_push_mux.sv
module ctx_push_mux
    import ctx_pkg::*;
(
    input  logic [CNT_W-1:0] idx,
    input  logic [PC_W-1:0]  pc,
    input  logic [7:0]       x,
    input  logic [7:0]       a,
    input  logic [7:0]       ccr,
    output logic [7:0]       byte_o
);

    // Slot k of the frame holds the byte written on the k-th push.
    logic [7:0] slot [FRAME_BYTES];

    assign slot[0] = pc[7:0];
    assign slot[1] = pc[15:8];
    assign slot[2] = x;
    assign slot[3] = a;
    assign slot[4] = ccr;

    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < FRAME_BYTES; k++) begin
            if (idx == CNT_W'(k)) begin
                byte_o = slot[k];
            end
        end
    end

endmodule

// File: rtl/ctx_addr_gen.sv
module ctx_addr_gen
    import ctx_pkg::*;
#(
    parameter int               AW         = 16,
    parameter int               SP_BITS    = 6,
    parameter logic [AW-1:0]    STACK_BASE = 16'h00C0
) (
    input  seq_state_e          st,
    input  logic [SP_BITS-1:0]  sp,
    input  logic [AW-1:0]       vec_base,
    output logic [AW-1:0]       addr
);

    localparam logic [AW-1:0] PAGE_MASK = ~((AW'(1) << SP_BITS) - AW'(1));

    logic [SP_BITS-1:0] sp_inc;
    logic [AW-1:0]      page;
    logic [AW-1:0]      vec_even;
    logic [AW-1:0]      vec_odd;

    assign sp_inc   = sp + 1'b1;
    assign page     = STACK_BASE & PAGE_MASK;
    assign vec_even = vec_base & ~AW'(1);
    assign vec_odd  = vec_base | AW'(1);

    always_comb begin
        case (st)
            ST_VHI:  addr = vec_even;
            ST_VLO:  addr = vec_odd;
            ST_POP:  addr = page | AW'(sp_inc);
            default: addr = page | AW'(sp);
        endcase
    end

endmodule

// File: rtl/ctx_stacker.sv
module ctx_stacker
    import ctx_pkg::*;
#(
    parameter int               AW         = 16,
    parameter int               SP_BITS    = 6,
    parameter logic [AW-1:0]    STACK_BASE = 16'h00C0,
    parameter int               IBIT       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_take,
    input  logic              rti_take,
    input  logic [AW-1:0]     vec_base,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [7:0]        x_in,
    input  logic [7:0]        a_in,
    input  logic [7:0]        ccr_in,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [PC_W-1:0]   pc_out,
    output logic [7:0]        x_out,
    output logic [7:0]        a_out,
    output logic [7:0]        ccr_out,
    output logic              busy,
    output logic              done
);

    localparam logic [CNT_W-1:0]   LAST_IDX = CNT_W'(FRAME_BYTES - 1);
    localparam logic [SP_BITS-1:0] SP_TOP   = '1;

    typedef struct packed {
        seq_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [SP_BITS-1:0]  sp;
        logic [PC_W-1:0]     pc;
        logic [7:0]          x;
        logic [7:0]          a;
        logic [7:0]          ccr;
        logic                done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic [7:0] push_byte;

    ctx_push_mux u_push_mux (
        .idx    (seq_q.cnt),
        .pc     (seq_q.pc),
        .x      (seq_q.x),
        .a      (seq_q.a),
        .ccr    (seq_q.ccr),
        .byte_o (push_byte)
    );

    ctx_addr_gen #(
        .AW         (AW),
        .SP_BITS    (SP_BITS),
        .STACK_BASE (STACK_BASE)
    ) u_addr_gen (
        .st       (seq_q.st),
        .sp       (seq_q.sp),
        .vec_base (vec_base),
        .addr     (mem_addr)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        mem_we     = 1'b0;
        mem_re     = 1'b0;
        mem_wdata  = push_byte;
        case (seq_q.st)
            ST_IDLE: begin
                if (irq_take) begin
                    seq_d.st  = ST_PUSH;
                    seq_d.cnt = '0;
                    seq_d.pc  = pc_in;
                    seq_d.x   = x_in;
                    seq_d.a   = a_in;
                    seq_d.ccr = ccr_in;
                end else if (rti_take) begin
                    seq_d.st  = ST_POP;
                    seq_d.cnt = '0;
                end
            end
            ST_PUSH: begin
                mem_we   = 1'b1;
                seq_d.sp = seq_q.sp - 1'b1;
                if (seq_q.cnt == LAST_IDX) begin
                    seq_d.st        = ST_VHI;
                    seq_d.cnt       = '0;
                    seq_d.ccr[IBIT] = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_VHI: begin
                mem_re         = 1'b1;
                seq_d.pc[15:8] = mem_rdata;
                seq_d.st       = ST_VLO;
            end
            ST_VLO: begin
                mem_re        = 1'b1;
                seq_d.pc[7:0] = mem_rdata;
                seq_d.st      = ST_IDLE;
                seq_d.done    = 1'b1;
            end
            ST_POP: begin
                mem_re   = 1'b1;
                seq_d.sp = seq_q.sp + 1'b1;
                case (seq_q.cnt)
                    3'd0:    seq_d.ccr     = mem_rdata;
                    3'd1:    seq_d.a       = mem_rdata;
                    3'd2:    seq_d.x       = mem_rdata;
                    3'd3:    seq_d.pc[15:8] = mem_rdata;
                    default: seq_d.pc[7:0] = mem_rdata;
                endcase
                if (seq_q.cnt == LAST_IDX) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.cnt  = '0;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.cnt  <= '0;
            seq_q.sp   <= SP_TOP;
            seq_q.pc   <= '0;
            seq_q.x    <= '0;
            seq_q.a    <= '0;
            seq_q.ccr  <= '0;
            seq_q.done <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pc_out  = seq_q.pc;
    assign x_out   = seq_q.x;
    assign a_out   = seq_q.a;
    assign ccr_out = seq_q.ccr;
    assign busy    = (seq_q.st != ST_IDLE);
    assign done    = seq_q.done;

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R9

    AST_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || (mem_re && seq_q.st == ST_POP)) |->
        ((mem_addr >> SP_BITS) == (STACK_BASE >> SP_BITS))); // R9

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (seq_q.sp == $past(seq_q.sp) - 1'b1)); // R3

    AST_VEC_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_VLO) |-> (mem_re && mem_addr[0])); // R4

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(seq_q.st) == ST_VLO) |-> ccr_out[IBIT]); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && seq_q.cnt != LAST_IDX && seq_q.st == ST_PUSH) |=>
        (seq_q.st == ST_PUSH)); // R8

endmodule

// File: tb/ctx_stacker_tb.sv
module ctx_stacker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int SP_BITS    = 4;
    localparam logic [AW-1:0] BASE = 16'h00F0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_take = 1'b0;
    logic          rti_take = 1'b0;
    logic [AW-1:0] vec_base = '0;
    logic [15:0]   pc_in = '0;
    logic [7:0]    x_in = '0, a_in = '0, ccr_in = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_re;
    logic [7:0]    mem_wdata, mem_rdata;
    logic [15:0]   pc_out;
    logic [7:0]    x_out, a_out, ccr_out;
    logic          busy, done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [7:0] ram   [16];
    logic [7:0] model [16];
    logic [3:0] sp_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctx_stacker #(
        .AW         (AW),
        .SP_BITS    (SP_BITS),
        .STACK_BASE (BASE),
        .IBIT       (3)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_take  (irq_take),
        .rti_take  (rti_take),
        .vec_base  (vec_base),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .a_in      (a_in),
        .ccr_in    (ccr_in),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .pc_out    (pc_out),
        .x_out     (x_out),
        .a_out     (a_out),
        .ccr_out   (ccr_out),
        .busy      (busy),
        .done      (done)
    );

    function automatic logic [7:0] vbyte(input logic [15:0] ad);
        return ad[7:0] ^ ad[15:8] ^ 8'h3C;
    endfunction

    always_ff @(posedge clk) begin
        if (mem_we && mem_addr[15:4] == 12'h00F) begin
            ram[mem_addr[3:0]] <= mem_wdata;
        end
    end

    assign mem_rdata = (mem_addr[15:4] == 12'h00F) ? ram[mem_addr[3:0]] : vbyte(mem_addr);

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic entry(input logic [15:0] pc, input logic [7:0] x, input logic [7:0] a,
                         input logic [7:0] ccr, input logic [15:0] vb,
                         input bit both, input bit poke);
        logic [7:0] exp_b [5];
        logic [15:0] vpc;
        exp_b[0] = pc[7:0]; exp_b[1] = pc[15:8]; exp_b[2] = x; exp_b[3] = a; exp_b[4] = ccr;
        @(negedge clk);
        irq_take = 1'b1; rti_take = both; pc_in = pc; x_in = x; a_in = a; ccr_in = ccr;
        vec_base = vb;
        @(negedge clk);
        irq_take = 1'b0; rti_take = poke;
        pc_in = ~pc; x_in = ~x; a_in = ~a; ccr_in = ~ccr;
        for (int k = 0; k < 5; k++) begin
            chk(busy && mem_we && !mem_re, "R7 busy/we during push", {busy, mem_we, mem_re}, 3'b110);
            chk(mem_addr == {12'h00F, sp_m}, "R3 push address", mem_addr, {12'h00F, sp_m});
            chk(mem_wdata == exp_b[k], "R2 push byte order", mem_wdata, exp_b[k]);
            model[sp_m] = exp_b[k];
            sp_m = sp_m - 4'd1;
            if (k == 2) irq_take = poke;
            @(negedge clk);
        end
        irq_take = 1'b0; rti_take = 1'b0;
        chk(mem_re && !mem_we && mem_addr == {vb[15:1], 1'b0}, "R4 vector high read",
            mem_addr, {vb[15:1], 1'b0});
        @(negedge clk);
        chk(mem_re && !mem_we && mem_addr == {vb[15:1], 1'b1}, "R4 vector low read",
            mem_addr, {vb[15:1], 1'b1});
        @(negedge clk);
        vpc = {vbyte({vb[15:1], 1'b0}), vbyte({vb[15:1], 1'b1})};
        chk(done && !busy, "R7 done after 7 busy cycles", {done, busy}, 2'b10);
        chk(pc_out == vpc, "R4 handler address", pc_out, vpc);
        chk(ccr_out == (ccr | 8'h08), "R5 mask bit set", ccr_out, ccr | 8'h08);
        chk(x_out == x && a_out == a, "R5 x/a kept", {x_out, a_out}, {x, a});
        @(negedge clk);
        chk(!done && !busy && !mem_we && !mem_re, "R8 stray requests ignored, done one cycle",
            {done, busy, mem_we, mem_re}, 4'b0000);
    endtask

    task automatic leave();
        logic [7:0] got [5];
        @(negedge clk);
        rti_take = 1'b1;
        @(negedge clk);
        rti_take = 1'b0;
        for (int k = 0; k < 5; k++) begin
            sp_m = sp_m + 4'd1;
            chk(busy && mem_re && !mem_we, "R7 busy/re during pop", {busy, mem_re, mem_we}, 3'b110);
            chk(mem_addr == {12'h00F, sp_m}, "R3 pop address", mem_addr, {12'h00F, sp_m});
            got[k] = model[sp_m];
            @(negedge clk);
        end
        chk(done && !busy, "R7 done after 5 busy cycles", {done, busy}, 2'b10);
        chk(ccr_out == got[0], "R6 ccr restored", ccr_out, got[0]);
        chk(ccr_out[3] == got[0][3], "R6 mask bit restored", ccr_out[3], got[0][3]);
        chk(a_out == got[1] && x_out == got[2], "R6 a/x restored", {a_out, x_out}, {got[1], got[2]});
        chk(pc_out == {got[3], got[4]}, "R6 pc restored", pc_out, {got[3], got[4]});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        sp_m = 4'hF;
        for (int i = 0; i < 16; i++) begin ram[i] = 8'h00; model[i] = 8'h00; end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re, "R1 reset idle", {busy, done, mem_we, mem_re}, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 idle after reset", {busy, done}, 2'b00);
        // R1 top-of-page start is covered by the first push address check.
        for (int i = 0; i < 20; i++) begin
            entry(16'h1234 + 16'(i * 16'h0111), 8'(i * 7 + 1), 8'(i * 13 + 5),
                  (i % 2 == 0) ? (8'(i * 37) & 8'hF7) : (8'(i * 37) | 8'h08),
                  16'h1FF4 + 16'(2 * (i % 5)), (i % 4 == 2), (i % 3 == 1));
        end
        for (int i = 0; i < 20; i++) begin
            leave();
        end
        for (int i = 0; i < 6; i++) begin
            entry(16'hA000 + 16'(i), 8'(8'h40 + i), 8'(8'h80 + i),
                  (i % 2 == 0) ? 8'hC1 : 8'hCA, 16'h1FFC - 16'(2 * i), 1'b0, 1'b0);
            leave();
            chk(ccr_out[3] == ((i % 2 == 0) ? 1'b0 : 1'b1), "R6 mask returns to saved value",
                ccr_out[3], (i % 2 == 0) ? 1'b0 : 1'b1);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule